// File: doc/BRIEF.md
# Running Byte-Wise CRC-16 Engine

This block folds a byte stream into a 16-bit CRC, one byte per accepted beat, using a 256-entry lookup table. The table is built at elaboration time from a generator polynomial parameter, so no table content is written out by hand. The running value is kept between frames and is only returned to zero by an explicit clear. A long check can therefore be spread over many short frame slots, a few bytes in each.

Each byte marked as the last of a frame produces a result one cycle later. The result is the running value with only its low byte inverted (XOR with 0x00FF). Along with it the block flags whether the result equals a 16-bit check word that was presented with the last byte.

The byte input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high at all times, so a byte is taken on every cycle where `in_valid` is high and `clr` is low. The producer may keep `in_valid` high on consecutive cycles. Clear and the result pins are plain level and pulse signals.

Top module: `crc16_run_engine`

## Requirements
- R1: After reset `out_done`, `out_match` and `out_crc` are 0, `in_ready` is 1, and the running value is zero.
- R2: Each accepted byte updates the running value as an MSB-first CRC with zero initial value. The byte is XORed into bits 15:8, then the new value is the table entry selected by bits 15:8 XORed with the value shifted left by 8. With the default polynomial 0x1021, the ASCII bytes "123456789" sent after a clear give the result 0x313C.
- R3: The result equals the running value XORed with 0x00FF: the high byte passes unchanged and the low byte is inverted. A single byte 0x00 after a clear gives 0x00FF.
- R4: The running value is not reset at the end of a frame. A frame sent without a clear gives the CRC of every byte accepted since the last clear.
- R5: A high `clr` sets the running value to zero at the next edge. A byte presented in the same cycle is dropped and produces no `out_done`.
- R6: `out_done` is high for exactly the one cycle after the clock edge that accepts a byte with `in_last` high. `out_crc` keeps its value until the next such pulse.
- R7: `out_match` is valid while `out_done` is high. It is 1 when `out_crc` equals the `chk_word` sampled with the last byte, and 0 otherwise.
- R8: `in_ready` is always 1, and a byte is accepted on every cycle where `in_valid` is high and `clr` is low, including consecutive cycles.
- R9: Cycles with `in_valid` low and `clr` low leave the running value unchanged.
- R10: Table entry i is the CRC of the single byte i under the polynomial parameter `POLY`. With `POLY` = 0x8005, "123456789" after a clear gives 0xFE17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Zero the running value; has priority over a byte in the same cycle |
| in_valid | input | 1 | Byte present on `in_data` |
| in_ready | output | 1 | Always 1; the block takes a byte every cycle |
| in_data | input | 8 | Byte to fold into the CRC |
| in_last | input | 1 | Byte ends a frame; a result follows |
| chk_word | input | 16 | Expected result, sampled with the last byte |
| out_done | output | 1 | One-cycle pulse: result valid |
| out_crc | output | 16 | Corrected result, held between pulses |
| out_match | output | 1 | Result equals the sampled check word |

## Verification
The bench builds two instances that share their inputs. One uses the default polynomial 0x1021 and the other uses 0x8005. Both use the default output mask 0x00FF. Comparing the two against a bit-serial model on every frame shows that the table really follows `POLY` and is not fixed to one generator. The model is written without a table. The sequences covered are the well-known nine-byte check string, frames chained without a clear, a clear that collides with a last byte, and idle gaps inside a frame.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // CRC of the single byte idx, MSB first, zero start, no output mask.
  function automatic crc_t entry_of(input byte_t idx, input crc_t poly);
    crc_t c;
    c = crc_t'(idx) << (CRC_W - BYTE_W);
    for (int k = 0; k < BYTE_W; k++) begin
      if (c[CRC_W-1]) c = (c << 1) ^ poly;
      else            c = c << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc16_table.sv
module crc16_table
  import crc16_pkg::*;
#(
  parameter crc_t POLY = 16'h1021
) (
  input  byte_t addr,
  output crc_t  data
);
  localparam int DEPTH = 1 << BYTE_W;

  crc_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign tbl[g] = entry_of(byte_t'(g), POLY);
  end

  assign data = tbl[addr];
endmodule

// File: rtl/crc16_step.sv
module crc16_step
  import crc16_pkg::*;
#(
  parameter crc_t POLY = 16'h1021
) (
  input  crc_t  cur,
  input  byte_t din,
  output crc_t  nxt
);
  localparam int SH = CRC_W - BYTE_W;

  crc_t  mixed;
  crc_t  lut_val;

  assign mixed = cur ^ (crc_t'(din) << SH);

  crc16_table #(.POLY(POLY)) u_tbl (
    .addr (mixed[CRC_W-1:SH]),
    .data (lut_val)
  );

  assign nxt = lut_val ^ (mixed << BYTE_W);
endmodule

// File: rtl/crc16_result.sv
module crc16_result
  import crc16_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  crc_t value,
  input  crc_t chk,
  output logic done,
  output crc_t crc,
  output logic match
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      crc   <= '0;
      match <= 1'b0;
    end else begin
      done <= fire;
      if (fire) begin
        crc   <= value;
        match <= (value == chk);
      end
    end
  end

  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(fire));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(crc));
  p_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (match == (crc == $past(chk))));
endmodule

// File: rtl/crc16_run_engine.sv
module crc16_run_engine
  import crc16_pkg::*;
#(
  parameter logic [15:0] POLY    = 16'h1021,
  parameter logic [15:0] XOR_OUT = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic [15:0] chk_word,
  output logic        out_done,
  output logic [15:0] out_crc,
  output logic        out_match
);
  crc_t run_q;
  crc_t run_d;
  logic take;

  assign in_ready = 1'b1;
  assign take     = in_valid && !clr;

  crc16_step #(.POLY(POLY)) u_step (
    .cur (run_q),
    .din (in_data),
    .nxt (run_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (clr)  run_q <= '0;
    else if (take) run_q <= run_d;
  end

  crc16_result u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (take && in_last),
    .value (run_d ^ XOR_OUT),
    .chk   (chk_word),
    .done  (out_done),
    .crc   (out_crc),
    .match (out_match)
  );

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (run_q == '0));
  p_clear_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_done);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(run_q));
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr && in_last) |=> out_done);
endmodule

// File: tb/crc16_run_engine_bench.sv
module crc16_run_engine_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] P_A = 16'h1021;
  localparam logic [15:0] P_B = 16'h8005;
  localparam int NV = 13;
  // byte, last marker, clear before this byte
  localparam logic [7:0] V_BYTE [NV] = '{8'h00, 8'h01, 8'hFF, 8'h80, 8'hA5, 8'h5A, 8'h3C,
                                         8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 8'hBC};
  localparam logic       V_LAST [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
                                         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic       V_CLR  [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                                         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [7:0]  in_data = '0;
  logic [15:0] chk_word = '0;
  logic        rdy_a, done_a, match_a, rdy_b, done_b, match_b;
  logic [15:0] crc_a, crc_b;
  int errors = 0, checks = 0;
  logic [15:0] m_a = '0, m_b = '0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  crc16_run_engine #(.POLY(P_A)) u_crc16_run_engine (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(rdy_a),
    .in_data(in_data), .in_last(in_last), .chk_word(chk_word),
    .out_done(done_a), .out_crc(crc_a), .out_match(match_a));

  crc16_run_engine #(.POLY(P_B)) u_crc16_run_engine_p8005 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(rdy_b),
    .in_data(in_data), .in_last(in_last), .chk_word(chk_word),
    .out_done(done_b), .out_crc(crc_b), .out_match(match_b));

  function automatic logic [15:0] bit_model(input logic [15:0] c, input logic [7:0] b,
                                            input logic [15:0] poly);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c = c << 1;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one beat; returns at the following negedge, after the capturing edge
  task automatic beat(input logic [7:0] b, input logic last, input logic c, input logic [15:0] chk);
    in_valid = 1'b1; in_data = b; in_last = last; clr = c; chk_word = chk;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; clr = 1'b0;
    if (c) begin m_a = '0; m_b = '0; end
    else begin m_a = bit_model(m_a, b, P_A); m_b = bit_model(m_b, b, P_B); end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0; m_a = '0; m_b = '0;
  endtask

  task automatic check_frame(input string req, input logic [15:0] chk);
    check({req, " done"}, done_a, 1);
    check({req, " crc"}, crc_a, m_a ^ 16'h00FF);
    check({req, " R10 crc poly8005"}, crc_b, m_b ^ 16'h00FF);
    check({"R7 match"}, match_a, (m_a ^ 16'h00FF) == chk);
    @(negedge clk);
    check("R6 single-cycle done", done_a, 0);
    check("R6 hold crc", crc_a, m_a ^ 16'h00FF);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string s;
    logic [15:0] chk;
    int fr;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", done_a, 0);
    check("R1 crc", crc_a, 0);
    check("R1 match", match_a, 0);
    check("R1 ready", rdy_a, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero running value seen via a lone 0x00 byte (also R3)
    beat(8'h00, 1'b1, 1'b0, 16'h00FF);
    check("R1 R3 zero byte", crc_a, 16'h00FF);
    check("R7 match hit", match_a, 1);
    @(negedge clk);

    // table walk (R2 R4 R8 back-to-back beats)
    fr = 0;
    for (int i = 0; i < NV; i++) begin
      if (V_CLR[i]) pulse_clr();
      chk = bit_model(m_a, V_BYTE[i], P_A) ^ 16'h00FF;
      if (fr % 2 == 1) chk = chk ^ 16'h0001;   // odd frames mismatch
      beat(V_BYTE[i], V_LAST[i], 1'b0, chk);
      if (V_LAST[i]) begin
        check_frame("R4 R8 vector frame", chk);
        fr++;
      end
    end

    // R2 and R10: check string
    pulse_clr();
    s = "123456789";
    for (int i = 0; i < 9; i++) beat(s[i], i == 8, 1'b0, 16'h313C);
    check("R2 check string", crc_a, 16'h313C);
    check("R10 check string poly8005", crc_b, 16'hFE17);
    check("R7 match on check string", match_a, 1);
    check("R8 ready", rdy_b, 1);
    @(negedge clk);

    // R5 clear collides with last byte: dropped, no done, value zero
    beat(8'h77, 1'b1, 1'b1, 16'h0000);
    check("R5 no done on cleared beat", done_a, 0);
    beat(8'h00, 1'b1, 1'b0, 16'h1234);
    check("R5 zeroed value", crc_a, 16'h00FF);
    check("R7 mismatch", match_a, 0);
    @(negedge clk);

    // R9 idle gaps inside a frame
    pulse_clr();
    beat(8'h31, 1'b0, 1'b0, 16'h0);
    repeat (5) @(negedge clk);
    check("R9 no done while idle", done_a, 0);
    beat(8'h32, 1'b1, 1'b0, 16'h0);
    check_frame("R9 idle gap", 16'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule